// File: doc/BRIEF.md
# Priority-Masked Interrupt Request Controller

This block collects a set of maskable interrupt inputs and decides, on each clock, which single request the processor core takes. Each source has a pending latch, a 3-bit priority level and a sense mode. In edge mode a synchronized rising edge sets the latch. In level mode the latch is bypassed and the live synchronized input is used instead. A processor priority level (IPL) and a global disable flag sit beside the sources. A request is taken only when the disable flag is clear and the source's level is strictly above the IPL, so level 0 masks a source.

When a request is taken, the block raises a one-cycle accept strobe with the winning source index. On the same clock edge it clears that source's latch. A register write port lets software set or clear single pending bits and write each priority field, each sense mode, the disable flag and the IPL. Every one of these is separate storage. A read port returns one source's level and mode.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the disable flag reads 1, the IPL reads 0, every pending bit and every level field read 0, every source is in edge mode, and accept_o is 0.
- R2: While the disable flag is 1, accept_o stays 0 whatever the requests are.
- R3: In edge mode (mode bit 0), a rising edge on irq_i[i] sets pending_o[i]. The change is visible after the third rising clock edge that samples the input high, because of a two-stage synchronizer followed by edge detection.
- R4: A source is taken only if its level is strictly greater than the IPL. A level equal to the IPL is never taken.
- R5: A source whose level is 0 is never taken, even with IPL 0. Its pending bit stays set.
- R6: A taken request gives accept_o high for one cycle with accept_idx_o set to the source index, one cycle after qualifying. The same edge clears the pending bit, so one latched event is taken once. accept_idx_o is 0 when accept_o is 0.
- R7: When several sources qualify, the one with the highest level wins. Among equal levels, the lowest index wins.
- R8: A write with reg_sel_i = 0 sets pending bit reg_idx_i to reg_wdata_i[0]. This write wins over a same-cycle edge and over a same-cycle accept clear.
- R9: reg_sel_i = 1 writes a level, 2 writes a mode (wdata[0], 1 = level-sensed), 3 writes the disable flag (wdata[0]) and 4 writes the IPL. A write to one field leaves every other field and every pending bit unchanged.
- R10: In level mode a source's pending bit is ignored. The source is taken on every cycle in which its synchronized input is high and it qualifies. When the input is low it is not taken, even if its pending bit is 1.
- R11: A second rising edge that arrives while the pending bit is already set is absorbed, giving a single accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_SRC | Raw interrupt inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Field select: 0 pending, 1 level, 2 mode, 3 disable, 4 IPL |
| reg_idx_i | input | IDX_W | Source index for per-source writes |
| reg_wdata_i | input | LVL_W | Write data |
| rd_idx_i | input | IDX_W | Source index for readback |
| rd_level_o | output | LVL_W | Level of source rd_idx_i |
| rd_mode_o | output | 1 | Mode of source rd_idx_i |
| pending_o | output | N_SRC | Pending latches |
| dis_o | output | 1 | Global disable flag |
| ipl_o | output | LVL_W | Processor priority level |
| accept_o | output | 1 | One-cycle accept strobe |
| accept_idx_o | output | IDX_W | Index of the accepted source |

## Verification
The bench builds the block with N_SRC = 4, LVL_W = 3 and SYNC_STAGES = 2. Four sources are enough to place two at the same level for the tie rule and to keep a level-0 source beside them. They also leave one source free for level-sensed operation. The 3-bit levels bring the strict comparison within reach at equal, adjacent and extreme values (0 and 7). The two-stage synchronizer fixes the three-edge latency that the reference model counts.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    SEL_REQ  = 3'd0,
    SEL_LVL  = 3'd1,
    SEL_MODE = 3'd2,
    SEL_DIS  = 3'd3,
    SEL_IPL  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             live_i,
  input  logic             req_we_i,
  input  logic             lvl_we_i,
  input  logic             mode_we_i,
  input  logic [LVL_W-1:0] wdata_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic             dis_i,
  input  logic             take_i,
  output logic             pend_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             mode_o,
  output logic             qual_o
);
  logic             lat_q, mode_q;
  logic [LVL_W-1:0] lvl_q;
  logic             eff_req;

  // software write > new edge > accept clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= 1'b0;
      lvl_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (req_we_i)    lat_q <= wdata_i[0];
      else if (rise_i) lat_q <= 1'b1;
      else if (take_i) lat_q <= 1'b0;
      if (lvl_we_i)  lvl_q  <= wdata_i;
      if (mode_we_i) mode_q <= wdata_i[0];
    end
  end

  assign eff_req = mode_q ? live_i : lat_q;
  assign qual_o  = !dis_i && eff_req && (lvl_q > ipl_i);
  assign pend_o  = lat_q;
  assign lvl_o   = lvl_q;
  assign mode_o  = mode_q;

  AST_CLEAR_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !req_we_i && !rise_i |=> !lat_q); // R6
  AST_LVL0_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == '0) |-> !take_i); // R5
  AST_DIS_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> !take_i); // R2
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = 4,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            qual_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  output logic [N-1:0]            grant_o,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [LVL_W-1:0]        lvl_o
);
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    grant_o = '0;
    // strict '>' keeps the lowest index on ties
    for (int i = 0; i < N; i++) begin
      if (qual_i[i] && (!any_o || lvl_i[i] > lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
    if (any_o) grant_o[idx_o] = 1'b1;
  end

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant_o)); // R7
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_SRC       = 4,
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [LVL_W-1:0] reg_wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [LVL_W-1:0] rd_level_o,
  output logic             rd_mode_o,
  output logic [N_SRC-1:0] pending_o,
  output logic             dis_o,
  output logic [LVL_W-1:0] ipl_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] accept_idx_o
);
  logic [N_SRC-1:0]            live, rise, qual, grant, mode;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        any_win;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic                        dis_q, acc_q;
  logic [LVL_W-1:0]            ipl_q;
  logic [IDX_W-1:0]            idx_q;
  reg_sel_e                    sel;

  assign sel = reg_sel_e'(reg_sel_i);

  irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(live), .rise_o(rise)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_slot
    logic hit;
    assign hit = reg_we_i && (reg_idx_i == IDX_W'(i));
    irq_src_slot #(.LVL_W(LVL_W)) u_slot (
      .clk_i, .rst_ni,
      .rise_i   (rise[i]),
      .live_i   (live[i]),
      .req_we_i (hit && sel == SEL_REQ),
      .lvl_we_i (hit && sel == SEL_LVL),
      .mode_we_i(hit && sel == SEL_MODE),
      .wdata_i  (reg_wdata_i),
      .ipl_i    (ipl_q),
      .dis_i    (dis_q),
      .take_i   (grant[i]),
      .pend_o   (pending_o[i]),
      .lvl_o    (lvl[i]),
      .mode_o   (mode[i]),
      .qual_o   (qual[i])
    );
  end

  irq_arbiter #(.N(N_SRC), .LVL_W(LVL_W)) u_arb (
    .qual_i(qual), .lvl_i(lvl), .grant_o(grant),
    .any_o(any_win), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= 1'b1;
      ipl_q <= '0;
      acc_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (reg_we_i && sel == SEL_DIS) dis_q <= reg_wdata_i[0];
      if (reg_we_i && sel == SEL_IPL) ipl_q <= reg_wdata_i;
      acc_q <= any_win;
      idx_q <= any_win ? win_idx : '0;
    end
  end

  assign dis_o        = dis_q;
  assign ipl_o        = ipl_q;
  assign accept_o     = acc_q;
  assign accept_idx_o = idx_q;
  assign rd_level_o   = lvl[rd_idx_i];
  assign rd_mode_o    = mode[rd_idx_i];

  AST_ACCEPT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> $past(!dis_q)); // R2
  AST_ACCEPT_ABOVE_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_win |-> (win_lvl > ipl_q)); // R4
  AST_IDX_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_q |-> (idx_q == '0)); // R6
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int N = 4, LW = 3, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq = '0;
  logic we = 0;
  logic [2:0] sel = '0;
  logic [IW-1:0] idx = '0, rdi = '0;
  logic [LW-1:0] wd = '0;
  logic [LW-1:0] rd_level, ipl_o;
  logic rd_mode, dis_o, acc_o;
  logic [N-1:0] pend;
  logic [IW-1:0] acc_idx;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N), .LVL_W(LW), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_sel_i(sel),
    .reg_idx_i(idx), .reg_wdata_i(wd), .rd_idx_i(rdi), .rd_level_o(rd_level),
    .rd_mode_o(rd_mode), .pending_o(pend), .dis_o(dis_o), .ipl_o(ipl_o),
    .accept_o(acc_o), .accept_idx_o(acc_idx)
  );

  int vecs = 0, errs = 0;
  string req = "R1";
  int acc_cnt [N];

  // behavioural model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_lat = '0, m_mode = '0;
  int m_lvl [N] = '{default: 0};
  int m_ipl = 0, m_idx = 0;
  bit m_dis = 1, m_acc = 0;

  task automatic chk(bit ok, string r, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [N-1:0] edg, nlat;
    int best;
    edg = m_s2 & ~m_prev;
    best = -1;
    for (int i = 0; i < N; i++) begin
      bit e, q;
      e = m_mode[i] ? m_s2[i] : m_lat[i];
      q = !m_dis && e && (m_lvl[i] > m_ipl);
      if (q && (best < 0 || m_lvl[i] > m_lvl[best])) best = i;
    end
    for (int i = 0; i < N; i++) begin
      if (we && sel == 3'd0 && int'(idx) == i) nlat[i] = wd[0];
      else if (edg[i]) nlat[i] = 1'b1;
      else if (best == i) nlat[i] = 1'b0;
      else nlat[i] = m_lat[i];
    end
    if (we && sel == 3'd1) m_lvl[idx] = int'(wd);
    if (we && sel == 3'd2) m_mode[idx] = wd[0];
    if (we && sel == 3'd3) m_dis = wd[0];
    if (we && sel == 3'd4) m_ipl = int'(wd);
    m_lat = nlat;
    m_acc = (best >= 0);
    m_idx = (best >= 0) ? best : 0;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
    @(posedge clk); #1;
    chk(acc_o == m_acc, {req, " accept"}, acc_o, m_acc);
    chk(int'(acc_idx) == m_idx, {req, " index"}, acc_idx, m_idx);
    chk(pend == m_lat, {req, " pending"}, pend, m_lat);
    chk(dis_o == m_dis, {req, " disable"}, dis_o, m_dis);
    chk(int'(ipl_o) == m_ipl, {req, " ipl"}, ipl_o, m_ipl);
    chk(int'(rd_level) == m_lvl[rdi], {req, " level"}, rd_level, m_lvl[rdi]);
    chk(rd_mode == m_mode[rdi], {req, " mode"}, rd_mode, m_mode[rdi]);
    if (acc_o) acc_cnt[acc_idx]++;
  endtask

  task automatic wr(int s, int i, int d);
    we = 1; sel = 3'(s); idx = IW'(i); wd = LW'(d);
    step();
    we = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < N; i++) acc_cnt[i] = 0;
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    clr_cnt();
    #9; rst_n = 1; #1;
    // R1 reset state
    req = "R1";
    chk(dis_o == 1, "R1 disable after reset", dis_o, 1);
    chk(pend == 0 && acc_o == 0 && ipl_o == 0 && rd_level == 0 && rd_mode == 0,
        "R1 reset fields", pend, 0);
    // R9 configure levels
    req = "R9";
    wr(1, 0, 2); wr(1, 1, 5); wr(1, 2, 5); wr(1, 3, 0);
    rdi = 1; step();
    chk(rd_level == 5 && pend == 0 && dis_o == 1, "R9 level write isolated", rd_level, 5);
    // R3 edge latch, R2 disabled
    req = "R3";
    irq[0] = 1; step(); step();
    chk(pend[0] == 0, "R3 not before third edge", pend[0], 0);
    step();
    chk(pend[0] == 1, "R3 pending after third edge", pend[0], 1);
    irq[0] = 0;
    req = "R2"; clr_cnt(); idle(4);
    chk(acc_cnt[0] == 0, "R2 no accept while disabled", acc_cnt[0], 0);
    // R6 enable: single accept, latch cleared
    req = "R6"; clr_cnt();
    wr(3, 0, 0);
    chk(acc_o == 0, "R6 qualifies this cycle, accept next", acc_o, 0);
    step();
    chk(acc_o == 1 && acc_idx == 0 && pend[0] == 0, "R6 accept pulse", acc_idx, 0);
    idle(3);
    chk(acc_cnt[0] == 1, "R6 taken once", acc_cnt[0], 1);
    // R8 software set + R7 tie
    req = "R7"; clr_cnt();
    wr(3, 0, 1); wr(0, 2, 1); wr(0, 1, 1); wr(0, 0, 1);
    chk(pend == 4'b0111, "R8 software set", pend, 4'b0111);
    wr(3, 0, 0);
    step();
    chk(acc_o == 1 && acc_idx == 1, "R7 tie to lowest index", acc_idx, 1);
    step();
    chk(acc_o == 1 && acc_idx == 2, "R7 second of tie", acc_idx, 2);
    step();
    chk(acc_o == 1 && acc_idx == 0, "R7 lower level last", acc_idx, 0);
    idle(2);
    // R4 strict compare
    req = "R4"; clr_cnt();
    wr(4, 0, 5); wr(0, 1, 1); idle(3);
    chk(acc_cnt[1] == 0 && pend[1] == 1, "R4 equal level blocked", acc_cnt[1], 0);
    wr(4, 0, 4); idle(2);
    chk(acc_cnt[1] == 1, "R4 above ipl taken", acc_cnt[1], 1);
    // R5 level zero masks
    req = "R5"; clr_cnt();
    wr(4, 0, 0); wr(0, 3, 1); idle(4);
    chk(acc_cnt[3] == 0 && pend[3] == 1, "R5 level 0 never taken", acc_cnt[3], 0);
    wr(0, 3, 0);
    chk(pend[3] == 0, "R8 software clear", pend[3], 0);
    // R9 independence of disable/ipl/level writes
    req = "R9";
    rdi = 0; wr(1, 0, 7);
    chk(rd_level == 7 && dis_o == 0 && ipl_o == 0 && pend == 0, "R9 isolation", rd_level, 7);
    wr(4, 0, 7); wr(1, 0, 2);
    chk(ipl_o == 7 && rd_level == 2, "R9 ipl kept", ipl_o, 7);
    wr(4, 0, 0);
    // R8 write beats edge
    req = "R8";
    wr(3, 0, 1);
    irq[3] = 1; idle(2);
    wr(0, 3, 0);
    chk(pend[3] == 0, "R8 write beats edge", pend[3], 0);
    irq[3] = 0; idle(2);
    wr(3, 0, 0);
    // R10 level-sensed
    req = "R10"; clr_cnt();
    rdi = 2; wr(2, 2, 1); wr(0, 2, 1); idle(3);
    chk(acc_cnt[2] == 0, "R10 pending ignored when low", acc_cnt[2], 0);
    irq[2] = 1; idle(8);
    chk(acc_cnt[2] >= 5, "R10 repeated while high", acc_cnt[2], 5);
    irq[2] = 0; idle(3); clr_cnt(); idle(3);
    chk(acc_cnt[2] == 0, "R10 stops when low", acc_cnt[2], 0);
    wr(2, 2, 0); wr(0, 2, 0);
    // R11 edge absorbed
    req = "R11"; clr_cnt();
    wr(3, 0, 1);
    irq[0] = 1; idle(3); irq[0] = 0; idle(3);
    irq[0] = 1; idle(3); irq[0] = 0; idle(3);
    wr(3, 0, 0); idle(4);
    chk(acc_cnt[0] == 1, "R11 two edges one accept", acc_cnt[0], 1);
    // R7 higher level beats lower index
    req = "R7"; clr_cnt();
    wr(3, 0, 1); wr(1, 3, 7); wr(0, 0, 1); wr(0, 3, 1); wr(3, 0, 0);
    step();
    chk(acc_idx == 3, "R7 highest level wins", acc_idx, 3);
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule